// File: doc/BRIEF.md
# Cascaded Layer-Stack Word Serializer

This block models a single vertical data channel shared by every layer of a memory stack. Each layer has one register stage. The stages form a chain from the top of the stack down to the external port. In each frame, every stage captures its own layer's read word at the same moment. The chain then shifts downward, so the bottom port presents the words of all layers one after another, one word per fast cycle. A frame is `NUM_LAYERS` fast cycles long. Each layer reads once per frame, which is the base rate. The port carries `NUM_LAYERS` words per frame, so its rate is `NUM_LAYERS` times the base rate.

The stages do not all advance on every cycle. Each stage has its own rate generator, which issues a clock-enable strobe. The strobe lets stage k update on only `NUM_LAYERS - k` cycles of each frame. Stage 0, at the bottom, updates on every cycle. The top stage updates once per frame, at the base rate. The whole block runs on one fast clock.

A small controller sequences the frames. It has two states:
- `ST_IDLE` is entered on reset.
- The transition START moves it from `ST_IDLE` to `ST_RUN` when `frame_start` is sampled high.
- `ST_RUN` has one transition, WRAP, from the last slot of a frame back to slot 0. Frames then repeat with no gap.
- Only a reset leaves `ST_RUN`.

Top module: `tsv_cascade_serializer`

## Requirements
- R1: A synchronous reset clears the stages, the slot counter and the controller. In the cycle after a reset edge, `out_valid` is 0, `out_tag` is 0 and `lyr_ready` is all zeros.
- R2: In `ST_IDLE`, `lyr_ready` stays all zeros. Layer inputs are ignored and `out_valid` stays 0 until `frame_start` is sampled high.
- R3: When `frame_start` is sampled high in `ST_IDLE`, the next cycle is slot 0 of the first frame. In that cycle, all bits of `lyr_ready` are 1. From then on, `lyr_ready` is all ones in exactly one cycle of every `NUM_LAYERS` and all zeros in the other cycles.
- R4: `frame_start` asserted in `ST_RUN` has no effect on the frame cadence.
- R5: The port lags the capture slot by one cycle. In `ST_RUN`, `out_tag` is 0 in the cycle after a capture slot and then counts up by 1 each cycle, wrapping after `NUM_LAYERS - 1`. The tag value s names layer s, the layer whose word the port carries.
- R6: A word from layer k, accepted in a capture slot (`lyr_valid[k]` and `lyr_ready[k]` both high), appears unchanged on `out_data` exactly k+1 cycles later, with `out_tag` = k. Layer k's word occupies bits `[k*WORD_W +: WORD_W]` of `lyr_data`.
- R7: If layer k is not valid in a capture slot, `out_valid` is 0 in that layer's port slot. No other layer's word fills that slot.
- R8: The port delivers each layer's words in the order in which they were accepted.
- R9: With every layer valid in every frame, `out_valid` is high on every cycle of every frame, which gives `NUM_LAYERS` words per frame. To achieve this, stage k updates on only `NUM_LAYERS - k` cycles of a frame, and the top stage updates only in the capture slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast I/O clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Starts frame sequencing when sampled in `ST_IDLE` |
| lyr_valid | input | NUM_LAYERS | Per-layer read word valid |
| lyr_data | input | NUM_LAYERS*WORD_W | Per-layer read words; layer k is at `[k*WORD_W +: WORD_W]` |
| lyr_ready | output | NUM_LAYERS | Per-layer capture strobe, high in slot 0 of each frame |
| out_valid | output | 1 | Bottom port word valid |
| out_data | output | WORD_W | Bottom port word |
| out_tag | output | $clog2(NUM_LAYERS) | Layer number of the current port slot |

## Verification
The checker tests several properties on every cycle:
- the state after reset;
- that `lyr_ready` is all-or-none and never high on two consecutive cycles;
- that the tag returns to 0 one cycle after a capture slot;
- layer 0's one-cycle path, including its empty-slot case;
- that the top stage updates only in the capture slot.

Some behaviours only the bench can show, because they span many cycles: latencies of k+1 cycles for the upper layers, ordered delivery for each layer, insensitivity to `frame_start` pulses in the middle of a run, full-rate output over long runs, and recovery from a reset in the middle of a frame. The bench's queue-based reference model compares these on every clock.

// File: rtl/tsv_cascade_pkg.sv
package tsv_cascade_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ser_state_e;

endpackage

// File: rtl/tsv_layer_rate_gen.sv
// Per-layer strobe generator: fires on the capture slot and on the
// following BUDGET-1 cycles, then stays quiet until the next frame.
module tsv_layer_rate_gen #(
    parameter int NUM_LAYERS = 4,
    parameter int LAYER_IDX  = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_tick,
    output logic stage_en
);
    localparam int BUDGET = NUM_LAYERS - LAYER_IDX;
    localparam int CNT_W  = $clog2(NUM_LAYERS + 1);

    logic [CNT_W-1:0] budget_q;
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            budget_q <= CNT_W'(BUDGET);
            left_q   <= '0;
        end else if (frame_tick) begin
            left_q <= budget_q - CNT_W'(1);
        end else if (left_q != '0) begin
            left_q <= left_q - CNT_W'(1);
        end
    end

    assign stage_en = frame_tick || (left_q != '0);

endmodule

// File: rtl/tsv_cascade_stage.sv
// One layer's selection register: load the local word in the capture slot,
// otherwise take the word from the stage above, only when enabled.
module tsv_cascade_stage #(
    parameter int WORD_W    = 128,
    parameter int TAG_W     = 2,
    parameter int LAYER_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              insert,
    input  logic              loc_valid,
    input  logic [WORD_W-1:0] loc_data,
    input  logic              up_valid,
    input  logic [WORD_W-1:0] up_data,
    input  logic [TAG_W-1:0]  up_tag,
    output logic              q_valid,
    output logic [WORD_W-1:0] q_data,
    output logic [TAG_W-1:0]  q_tag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_data  <= '0;
            q_tag   <= '0;
        end else if (en) begin
            if (insert) begin
                q_valid <= loc_valid;
                q_data  <= loc_data;
                q_tag   <= TAG_W'(LAYER_IDX);
            end else begin
                q_valid <= up_valid;
                q_data  <= up_data;
                q_tag   <= up_tag;
            end
        end
    end

endmodule

// File: rtl/tsv_cascade_serializer.sv
module tsv_cascade_serializer #(
    parameter int NUM_LAYERS = 4,
    parameter int WORD_W     = 128,
    localparam int TAG_W     = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         frame_start,
    input  logic [NUM_LAYERS-1:0]        lyr_valid,
    input  logic [NUM_LAYERS*WORD_W-1:0] lyr_data,
    output logic [NUM_LAYERS-1:0]        lyr_ready,
    output logic                         out_valid,
    output logic [WORD_W-1:0]            out_data,
    output logic [TAG_W-1:0]             out_tag
);
    import tsv_cascade_pkg::*;

    localparam logic [TAG_W-1:0] LAST_SLOT = TAG_W'(NUM_LAYERS - 1);

    ser_state_e         state_q;
    ser_state_e         state_d;
    logic [TAG_W-1:0]   slot_q;
    logic [TAG_W-1:0]   slot_d;
    logic               frame_tick;
    logic [NUM_LAYERS-1:0] stage_en;

    logic              stg_valid [0:NUM_LAYERS];
    logic [WORD_W-1:0] stg_data  [0:NUM_LAYERS];
    logic [TAG_W-1:0]  stg_tag   [0:NUM_LAYERS];

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        slot_d     = slot_q;
        frame_tick = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (frame_start) begin          // START
                    state_d = ST_RUN;
                    slot_d  = '0;
                end
            end
            ST_RUN: begin
                frame_tick = (slot_q == '0);
                if (slot_q == LAST_SLOT) begin  // WRAP
                    slot_d = '0;
                end else begin
                    slot_d = slot_q + TAG_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign lyr_ready = {NUM_LAYERS{frame_tick}};

    // Nothing above the top layer
    assign stg_valid[NUM_LAYERS] = 1'b0;
    assign stg_data[NUM_LAYERS]  = '0;
    assign stg_tag[NUM_LAYERS]   = '0;

    for (genvar k = 0; k < NUM_LAYERS; k++) begin : g_layer
        tsv_layer_rate_gen #(
            .NUM_LAYERS (NUM_LAYERS),
            .LAYER_IDX  (k)
        ) u_rate (
            .clk        (clk),
            .rst        (rst),
            .frame_tick (frame_tick),
            .stage_en   (stage_en[k])
        );

        tsv_cascade_stage #(
            .WORD_W    (WORD_W),
            .TAG_W     (TAG_W),
            .LAYER_IDX (k)
        ) u_stage (
            .clk       (clk),
            .rst       (rst),
            .en        (stage_en[k]),
            .insert    (frame_tick),
            .loc_valid (lyr_valid[k]),
            .loc_data  (lyr_data[k*WORD_W +: WORD_W]),
            .up_valid  (stg_valid[k+1]),
            .up_data   (stg_data[k+1]),
            .up_tag    (stg_tag[k+1]),
            .q_valid   (stg_valid[k]),
            .q_data    (stg_data[k]),
            .q_tag     (stg_tag[k])
        );
    end

    assign out_valid = stg_valid[0];
    assign out_data  = stg_data[0];
    assign out_tag   = stg_tag[0];

endmodule

// File: rtl/tsv_cascade_serializer_chk.sv
module tsv_cascade_serializer_chk #(
    parameter int NUM_LAYERS = 4,
    parameter int WORD_W     = 128,
    parameter int TAG_W      = 2
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_LAYERS-1:0]        lyr_valid,
    input logic [NUM_LAYERS*WORD_W-1:0] lyr_data,
    input logic [NUM_LAYERS-1:0]        lyr_ready,
    input logic                         out_valid,
    input logic [WORD_W-1:0]            out_data,
    input logic [TAG_W-1:0]             out_tag,
    input logic [NUM_LAYERS-1:0]        stage_en
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!out_valid && out_tag == '0 && lyr_ready == '0)); // R1

    AST_READY_ALL_OR_NONE: assert property (@(posedge clk) disable iff (rst)
        (lyr_ready == '0 || lyr_ready == '1)); // R3

    if (NUM_LAYERS > 1) begin : g_gap
        AST_READY_GAP: assert property (@(posedge clk) disable iff (rst)
            lyr_ready[0] |=> !lyr_ready[0]); // R3
    end

    AST_TAG_RESTART: assert property (@(posedge clk) disable iff (rst)
        lyr_ready[0] |=> (out_tag == '0)); // R5

    AST_BOTTOM_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (lyr_ready[0] && lyr_valid[0]) |=>
            (out_valid && out_data == $past(lyr_data[WORD_W-1:0]))); // R6

    AST_EMPTY_SLOT: assert property (@(posedge clk) disable iff (rst)
        (lyr_ready[0] && !lyr_valid[0]) |=> !out_valid); // R7

    AST_TOP_BASE_RATE: assert property (@(posedge clk) disable iff (rst)
        stage_en[NUM_LAYERS-1] |-> lyr_ready[0]); // R9

endmodule

bind tsv_cascade_serializer tsv_cascade_serializer_chk #(
    .NUM_LAYERS (NUM_LAYERS),
    .WORD_W     (WORD_W),
    .TAG_W      (TAG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lyr_valid (lyr_valid),
    .lyr_data  (lyr_data),
    .lyr_ready (lyr_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_tag   (out_tag),
    .stage_en  (stage_en)
);

// File: tb/tsv_cascade_serializer_tb_top.sv
module tsv_cascade_serializer_tb_top;
    localparam int NL       = 4;
    localparam int W        = 128;
    localparam int TW       = 2;
    localparam int CLK_PER  = 10;
    localparam int WATCHDOG = 100000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frame_start = 1'b0;
    logic [NL-1:0]     lyr_valid = '0;
    logic [NL*W-1:0]   lyr_data = '0;
    logic [NL-1:0]     lyr_ready;
    logic              out_valid;
    logic [W-1:0]      out_data;
    logic [TW-1:0]     out_tag;

    always #(CLK_PER/2) clk = ~clk;

    tsv_cascade_serializer #(.NUM_LAYERS(NL), .WORD_W(W)) dut_i (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .lyr_valid(lyr_valid), .lyr_data(lyr_data), .lyr_ready(lyr_ready),
        .out_valid(out_valid), .out_data(out_data), .out_tag(out_tag)
    );

    typedef struct { logic [W-1:0] d; int due; } exp_t;
    exp_t q_exp [NL][$];
    int   slot_layer [int];
    bit   slot_valid [int];

    int  n_chk = 0, n_fail = 0, cyc = 0;
    bit  m_run = 0, m_last_rst = 0, done = 0;
    int  m_phase = 0, fs_recent = 0;
    int  vmode = 0;   // 0 all valid, 1 random, 2 none

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    task automatic step(input bit rst_v, input bit fs_v);
        logic [NL-1:0] exp_rdy;
        @(negedge clk);
        cyc++;
        // ---- compare port against model ----
        exp_rdy = (m_run && m_phase == 0) ? '1 : '0;
        if (m_last_rst) begin
            chk(out_valid == 1'b0, "R1", W'(out_valid), '0);
            chk(out_tag == '0, "R1", W'(out_tag), '0);
            chk(lyr_ready == '0, "R1", W'(lyr_ready), '0);
        end else begin
            chk(lyr_ready == exp_rdy, !m_run ? "R2" : (fs_recent > 0 ? "R4" : "R3"),
                W'(lyr_ready), W'(exp_rdy));
            if (slot_layer.exists(cyc)) begin
                int k = slot_layer[cyc];
                chk(out_tag == TW'(k), "R5", W'(out_tag), W'(k));
                chk(out_valid == slot_valid[cyc], "R7/R9", W'(out_valid), W'(slot_valid[cyc]));
                if (out_valid && slot_valid[cyc] && q_exp[k].size() > 0) begin
                    exp_t e = q_exp[k].pop_front();
                    chk(out_data == e.d, "R8", out_data, e.d);
                    chk(e.due == cyc, "R6", W'(cyc), W'(e.due));
                end
                slot_layer.delete(cyc);
                slot_valid.delete(cyc);
            end else begin
                chk(out_valid == 1'b0, "R2", W'(out_valid), '0);
            end
        end
        if (fs_recent > 0) fs_recent--;
        // ---- drive inputs for this cycle ----
        rst = rst_v;
        frame_start = fs_v;
        for (int k = 0; k < NL; k++) begin
            logic [W-1:0] d;
            for (int b = 0; b < W; b += 32) d[b +: 32] = $urandom;
            lyr_data[k*W +: W] = d;
            lyr_valid[k] = (vmode == 0) ? 1'b1 : (vmode == 2) ? 1'b0 : 1'($urandom_range(0, 1));
        end
        // ---- model update for the coming edge ----
        m_last_rst = rst_v;
        if (rst_v) begin
            m_run = 0; m_phase = 0; fs_recent = 0;
            for (int k = 0; k < NL; k++) q_exp[k].delete();
            slot_layer.delete(); slot_valid.delete();
        end else if (m_run) begin
            if (m_phase == 0) begin
                for (int k = 0; k < NL; k++) begin
                    slot_layer[cyc + k + 1] = k;
                    slot_valid[cyc + k + 1] = lyr_valid[k];
                    if (lyr_valid[k]) q_exp[k].push_back('{lyr_data[k*W +: W], cyc + k + 1});
                end
            end
            if (fs_v) fs_recent = NL + 1;
            m_phase = (m_phase + 1) % NL;
        end else if (fs_v) begin
            m_run = 1; m_phase = 0;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 reset, then R2 idle with valid inputs present
        repeat (3) step(1, 0);
        vmode = 0;
        repeat (6) step(0, 0);
        // R3 start, R9 full rate
        step(0, 1);
        repeat (24) step(0, 0);
        // R7 random gaps, R4 frame_start pulses while running
        vmode = 1;
        for (int i = 0; i < 60; i++) step(0, (i % 13) == 5);
        vmode = 2;
        repeat (10) step(0, 0);
        // reset in the middle of a frame, restart
        vmode = 0;
        repeat (2) step(1, 0);
        repeat (3) step(0, 0);
        step(0, 1);
        repeat (17) step(0, 0);
        // long mixed run (R6, R8)
        vmode = 1;
        for (int i = 0; i < 2000; i++) step(0, (i % 97) == 3);
        vmode = 0;
        repeat (40) step(0, 0);
        repeat (8) step(0, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule